// File: doc/BRIEF.md
# Aggregated receive stream deframer

This block takes one bulk receive transfer at a time as a byte stream, with a marker on the last byte of the transfer, and splits it into the Ethernet frames packed inside it. Each frame in the transfer starts with a 3-byte header: a status byte, then a little-endian 16-bit length. The payload follows, then a frame check sequence (FCS). The length counts the payload plus the FCS. Frames sit back to back. The payload bytes go out on a streaming output whose last flag marks the final payload byte of each frame. The header and FCS bytes are used up inside the block and never leave it. The FCS is not checked.

A header that is not acceptable stops parsing for the rest of the transfer. So does a transfer that ends in the middle of a frame. In either case the block pulses an error output with a code and then discards input until the end marker. The parser starts fresh with the first byte after each end marker. Output backpressure stalls the input only while payload is passing. Header and FCS bytes are accepted at every cycle.

Top module: `agg_rx_deframer`

## Requirements
- R1: After reset, in_ready is 1, m_tvalid is 0 and err_valid is 0.
- R2: Within a frame, byte 0 is the status, byte 1 is the low length byte and byte 2 is the high length byte. Payload length equals the length field minus FCS_BYTES. Only payload bytes appear on m_tdata, in order and unchanged, with m_tvalid high in the same cycle the byte is offered on the input. Header and FCS bytes never raise m_tvalid.
- R3: m_tlast is high on the final payload byte of every frame.
- R4: A transfer may hold several frames back to back. A frame whose FCS ends exactly on the end-marked byte completes with no error.
- R5: While a payload byte is offered, in_ready equals m_tready. A header, FCS or discarded byte is accepted with in_ready high.
- R6: A status byte other than GOOD_STATUS (0x40 by default) gives error code 1. Every further byte up to and including the end-marked one is consumed with no output and no further error.
- R7: A length field below FCS_BYTES+1, or above MAX_PAYLOAD+FCS_BYTES, gives error code 2 on the high length byte. The rest of the transfer is then discarded as in R6.
- R8: A transfer that ends after fewer than 3+FCS_BYTES bytes, and has not already raised an error, gives error code 0 (runt).
- R9: Any longer transfer that ends inside a frame gives error code 3 (truncated). If it ends inside the payload, the end-marked byte is forwarded with m_tlast high.
- R10: err_valid is high for exactly the one cycle after the byte that caused the error is accepted. Each transfer raises at most one error. The first byte after an end marker is parsed as a new status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a transfer |
| m_tvalid | output | 1 | Payload byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 8 | Payload byte |
| m_tlast | output | 1 | Final payload byte of a frame |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 0 runt, 1 bad status, 2 bad length, 3 truncated |

## Verification
The bench builds the block with MAX_PAYLOAD set to 40 and the default FCS_BYTES of 4. With that limit, the largest legal payload and the first rejected length can both be reached with short transfers. The bench also uses a length field whose high byte is nonzero, so the upper length byte matters to the length check. Random input gaps and random m_tready stalls fall on payload, header and FCS bytes alike. This exercises the per-byte ready rule across every parse phase.

// File: rtl/agg_rx_deframer_pkg.sv
package agg_rx_deframer_pkg;

    localparam int HDR_BYTES = 3;

    typedef enum logic [2:0] {
        ST_STATUS = 3'd0,
        ST_LEN_LO = 3'd1,
        ST_LEN_HI = 3'd2,
        ST_BODY   = 3'd3,
        ST_FCS    = 3'd4,
        ST_FLUSH  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        ERR_RUNT   = 2'd0,
        ERR_STATUS = 2'd1,
        ERR_LENGTH = 2'd2,
        ERR_TRUNC  = 2'd3
    } fault_e;

endpackage

// File: rtl/agg_rx_hdr_check.sv
module agg_rx_hdr_check #(
    parameter int          MAX_PAYLOAD = 1514,
    parameter int          FCS_BYTES   = 4,
    parameter logic [7:0]  GOOD_STATUS = 8'h40,
    parameter int          PAY_W       = 11
) (
    input  logic [7:0]       status_byte,
    input  logic [7:0]       len_lo,
    input  logic [7:0]       len_hi,
    output logic             status_ok,
    output logic             len_ok,
    output logic [PAY_W-1:0] pay_len
);
    localparam logic [16:0] LO_LIM = 17'(FCS_BYTES + 1);
    localparam logic [16:0] HI_LIM = 17'(MAX_PAYLOAD + FCS_BYTES);
    localparam logic [16:0] FCS_V  = 17'(FCS_BYTES);

    logic [16:0] field;

    always_comb begin
        field     = {1'b0, len_hi, len_lo};
        status_ok = (status_byte == GOOD_STATUS);
        len_ok    = (field >= LO_LIM) && (field <= HI_LIM);
        pay_len   = PAY_W'(field - FCS_V);
    end
endmodule

// File: rtl/agg_rx_xfer_count.sv
module agg_rx_xfer_count #(
    parameter int OVERHEAD = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic end_mark,
    output logic runt_now
);
    localparam int              CNT_W = (OVERHEAD > 2) ? $clog2(OVERHEAD) : 1;
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(OVERHEAD - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take) begin
            if (end_mark)
                cnt_d = '0;
            else if (cnt_q != SAT)
                cnt_d = cnt_q + CNT_W'(1);
        end
        // bytes before this one fewer than OVERHEAD-1 -> total below OVERHEAD
        runt_now = (cnt_q < SAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/agg_rx_deframer.sv
module agg_rx_deframer
    import agg_rx_deframer_pkg::*;
#(
    parameter int         MAX_PAYLOAD = 1514,
    parameter int         FCS_BYTES   = 4,
    parameter logic [7:0] GOOD_STATUS = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       m_tvalid,
    input  logic       m_tready,
    output logic [7:0] m_tdata,
    output logic       m_tlast,
    output logic       err_valid,
    output logic [1:0] err_code
);
    localparam int OVERHEAD = HDR_BYTES + FCS_BYTES;
    localparam int PAY_W    = $clog2(MAX_PAYLOAD + 1);
    localparam int FCS_W    = $clog2(FCS_BYTES + 1);

    typedef struct packed {
        phase_e           phase;
        logic [7:0]       len_lo;
        logic [PAY_W-1:0] body_left;
        logic [FCS_W-1:0] fcs_left;
        logic             err_v;
        fault_e           err_code;
    } ctl_t;

    ctl_t d, q;

    logic             status_ok;
    logic             len_ok;
    logic [PAY_W-1:0] pay_len;
    logic             runt_now;
    logic             take;
    logic             in_body;
    fault_e           short_code;

    agg_rx_hdr_check #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .FCS_BYTES   (FCS_BYTES),
        .GOOD_STATUS (GOOD_STATUS),
        .PAY_W       (PAY_W)
    ) u_hdr (
        .status_byte (in_data),
        .len_lo      (q.len_lo),
        .len_hi      (in_data),
        .status_ok   (status_ok),
        .len_ok      (len_ok),
        .pay_len     (pay_len)
    );

    agg_rx_xfer_count #(
        .OVERHEAD (OVERHEAD)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .end_mark (in_last),
        .runt_now (runt_now)
    );

    always_comb begin
        in_body    = (q.phase == ST_BODY);
        in_ready   = in_body ? m_tready : 1'b1;
        take       = in_valid && in_ready;
        m_tvalid   = in_body && in_valid;
        m_tdata    = in_data;
        m_tlast    = m_tvalid && ((q.body_left == PAY_W'(1)) || in_last);
        err_valid  = q.err_v;
        err_code   = q.err_code;
        short_code = runt_now ? ERR_RUNT : ERR_TRUNC;
    end

    always_comb begin
        d       = q;
        d.err_v = 1'b0;
        if (take) begin
            case (q.phase)
                ST_STATUS: begin
                    if (!status_ok) begin
                        d.err_v    = 1'b1;
                        d.err_code = ERR_STATUS;
                        d.phase    = in_last ? ST_STATUS : ST_FLUSH;
                    end else if (in_last) begin
                        d.err_v    = 1'b1;
                        d.err_code = short_code;
                        d.phase    = ST_STATUS;
                    end else begin
                        d.phase    = ST_LEN_LO;
                    end
                end
                ST_LEN_LO: begin
                    d.len_lo = in_data;
                    if (in_last) begin
                        d.err_v    = 1'b1;
                        d.err_code = short_code;
                        d.phase    = ST_STATUS;
                    end else begin
                        d.phase    = ST_LEN_HI;
                    end
                end
                ST_LEN_HI: begin
                    if (!len_ok) begin
                        d.err_v    = 1'b1;
                        d.err_code = ERR_LENGTH;
                        d.phase    = in_last ? ST_STATUS : ST_FLUSH;
                    end else if (in_last) begin
                        d.err_v    = 1'b1;
                        d.err_code = short_code;
                        d.phase    = ST_STATUS;
                    end else begin
                        d.body_left = pay_len;
                        d.phase     = ST_BODY;
                    end
                end
                ST_BODY: begin
                    d.body_left = q.body_left - PAY_W'(1);
                    if (in_last) begin
                        d.err_v    = 1'b1;
                        d.err_code = short_code;
                        d.phase    = ST_STATUS;
                    end else if (q.body_left == PAY_W'(1)) begin
                        d.fcs_left = FCS_W'(FCS_BYTES);
                        d.phase    = ST_FCS;
                    end
                end
                ST_FCS: begin
                    d.fcs_left = q.fcs_left - FCS_W'(1);
                    if (q.fcs_left == FCS_W'(1)) begin
                        d.phase    = ST_STATUS;
                    end else if (in_last) begin
                        d.err_v    = 1'b1;
                        d.err_code = short_code;
                        d.phase    = ST_STATUS;
                    end
                end
                ST_FLUSH: begin
                    if (in_last) d.phase = ST_STATUS;
                end
                default: d.phase = ST_STATUS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/agg_rx_deframer_chk.sv
module agg_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       in_last,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic [7:0] m_tdata,
    input logic       m_tlast,
    input logic       err_valid,
    input logic [1:0] err_code
);
    p_data_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (in_valid && (m_tdata == in_data)));

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (in_ready == m_tready));

    p_end_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && in_last) |-> m_tlast);

    p_err_follows_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(in_valid && in_ready));

    p_short_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && ((err_code == 2'd0) || (err_code == 2'd3))) |-> $past(in_last));

    p_last_has_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);
endmodule

bind agg_rx_deframer agg_rx_deframer_chk u_chk (.*);

// File: tb/agg_rx_deframer_bench.sv
module agg_rx_deframer_bench;
    localparam int MAXP = 40;
    localparam int FCSN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       m_tvalid;
    logic       m_tready = 1'b0;
    logic [7:0] m_tdata;
    logic       m_tlast;
    logic       err_valid;
    logic [1:0] err_code;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    agg_rx_deframer #(.MAX_PAYLOAD(MAXP), .FCS_BYTES(FCSN)) u_agg_rx_deframer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .err_valid(err_valid), .err_code(err_code));

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0: return "R8";
            1: return "R6";
            2: return "R7";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic add_frame(ref logic [7:0] q[$], input logic [7:0] st,
                             input int fld, input int nbody, input int seed);
        q.push_back(st);
        q.push_back(fld[7:0]);
        q.push_back(fld[15:8]);
        for (int k = 0; k < nbody; k++) q.push_back(8'((seed + 3 * k) & 255));
        for (int k = 0; k < FCSN; k++) q.push_back(8'(8'hC0 + k));
    endtask

    task automatic run_xfer(input logic [7:0] x[$]);
        int n;
        int fwd[];
        int lst[];
        int errc[];
        int pos;
        int sc;
        bit stop;
        int i;
        int pend;
        int exp_last_cnt;
        int obs_last_cnt;
        bit acc;
        n = x.size();
        fwd = new[n];
        lst = new[n];
        errc = new[n];
        for (int k = 0; k < n; k++) begin fwd[k] = 0; lst[k] = 0; errc[k] = -1; end
        sc = (n < 3 + FCSN) ? 0 : 3;
        pos = 0;
        stop = 0;
        while (pos < n && !stop) begin
            int f;
            int fld;
            int pl;
            f = pos;
            if (x[f] != 8'h40) begin errc[f] = 1; stop = 1; end
            else if (f == n - 1) begin errc[f] = sc; stop = 1; end
            else if (f + 1 == n - 1) begin errc[f + 1] = sc; stop = 1; end
            else begin
                fld = int'(x[f + 1]) + 256 * int'(x[f + 2]);
                if (fld < FCSN + 1 || fld > MAXP + FCSN) begin errc[f + 2] = 2; stop = 1; end
                else if (f + 2 == n - 1) begin errc[f + 2] = sc; stop = 1; end
                else begin
                    pl = fld - FCSN;
                    for (int k = 0; k < pl && !stop; k++) begin
                        int idx;
                        idx = f + 3 + k;
                        fwd[idx] = 1;
                        lst[idx] = (k == pl - 1 || idx == n - 1) ? 1 : 0;
                        if (idx == n - 1) begin errc[idx] = sc; stop = 1; end
                    end
                    for (int k = 0; k < FCSN && !stop; k++) begin
                        int idx;
                        idx = f + 3 + pl + k;
                        if (idx == n - 1 && k != FCSN - 1) begin errc[idx] = sc; stop = 1; end
                    end
                    pos = f + 3 + pl + FCSN;
                end
            end
        end
        exp_last_cnt = 0;
        for (int k = 0; k < n; k++) exp_last_cnt += lst[k];
        obs_last_cnt = 0;
        i = 0;
        pend = -1;
        while (i < n) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_data  = x[i];
            in_last  = (i == n - 1);
            m_tready = ($urandom % 3) != 0;
            #2;
            check(tag_of(pend), int'(err_valid), (pend >= 0) ? 1 : 0);
            if (pend >= 0) check(tag_of(pend), int'(err_code), pend);
            if (in_valid) begin
                check("R2", int'(m_tvalid), fwd[i]);
                if (fwd[i] != 0) begin
                    check("R2", int'(m_tdata), int'(x[i]));
                    check("R3", int'(m_tlast), lst[i]);
                    check("R5", int'(in_ready), int'(m_tready));
                end else begin
                    check("R5", int'(in_ready), 1);
                end
            end else begin
                check("R2", int'(m_tvalid), 0);
            end
            acc = in_valid && in_ready;
            if (acc && m_tvalid && m_tlast) obs_last_cnt++;
            @(posedge clk);
            if (acc) begin pend = errc[i]; i++; end
            else pend = -1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #2;
        check(tag_of(pend), int'(err_valid), (pend >= 0) ? 1 : 0);
        if (pend >= 0) check(tag_of(pend), int'(err_code), pend);
        check("R4", obs_last_cnt, exp_last_cnt);
    endtask

    initial begin
        logic [7:0] q[$];
        repeat (3) @(posedge clk);
        #2;
        check("R1", int'(in_ready), 1);
        check("R1", int'(m_tvalid), 0);
        check("R1", int'(err_valid), 0);
        rst_n = 1'b1;
        @(posedge clk);

        // R2 R3: one frame that fills the transfer exactly
        q = {}; add_frame(q, 8'h40, 14, 10, 1); run_xfer(q);
        // R4: three frames back to back
        q = {}; add_frame(q, 8'h40, 5, 1, 7); add_frame(q, 8'h40, 11, 7, 20);
        add_frame(q, 8'h40, 24, 20, 90); run_xfer(q);
        // R6: bad status on the first frame, the rest is discarded
        q = {}; add_frame(q, 8'h41, 10, 6, 3); add_frame(q, 8'h40, 10, 6, 5); run_xfer(q);
        // R6: bad status on the second frame
        q = {}; add_frame(q, 8'h40, 7, 3, 11); add_frame(q, 8'h00, 7, 3, 12);
        add_frame(q, 8'h40, 6, 2, 13); run_xfer(q);
        // R7: largest legal payload then one byte over the limit
        q = {}; add_frame(q, 8'h40, MAXP + FCSN, MAXP, 40); add_frame(q, 8'h40, MAXP + FCSN + 1, 2, 41);
        run_xfer(q);
        // R7: length field too small
        q = {}; add_frame(q, 8'h40, FCSN, 0, 0); q.push_back(8'h40); q.push_back(8'h09); run_xfer(q);
        // R7: high length byte nonzero
        q = {}; add_frame(q, 8'h40, 16'h0105, 3, 2); run_xfer(q);
        // R8: runt transfer ending inside the payload
        q = {8'h40, 8'h09, 8'h00, 8'hAA, 8'hBB}; run_xfer(q);
        // R8: runt ending on the status byte
        q = {8'h40}; run_xfer(q);
        // R9: truncated inside the payload
        q = {}; add_frame(q, 8'h40, 34, 30, 60);
        while (q.size() > 20) void'(q.pop_back());
        run_xfer(q);
        // R9: truncated inside the FCS
        q = {}; add_frame(q, 8'h40, 10, 6, 70); void'(q.pop_back()); void'(q.pop_back()); run_xfer(q);
        // R9: leftover bytes after a complete frame
        q = {}; add_frame(q, 8'h40, 8, 4, 80); q.push_back(8'h40); q.push_back(8'h05);
        q.push_back(8'h00); run_xfer(q);
        // R6 R10: single bad status byte that is also the end marker, then a clean transfer
        q = {8'h13}; run_xfer(q);
        q = {}; add_frame(q, 8'h40, 6, 2, 99); run_xfer(q);
        // R10: runt then immediately a good transfer
        q = {8'h40, 8'h06}; run_xfer(q);
        q = {}; add_frame(q, 8'h40, 9, 5, 17); add_frame(q, 8'h40, 5, 1, 18); run_xfer(q);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule